// File: doc/BRIEF.md
# Stack and Call/Return Sequencer

This block is a multi-cycle sequencer that owns a 16-bit program counter and a 16-bit stack pointer. It runs four stack operations through a byte-wide memory port: saving a register pair, restoring a register pair, calling a subroutine and returning from one. A single start strobe with an operation code begins an operation. The sequencer then steps through a fixed schedule of machine cycles, one T-state per clock. It drives the address, the write data and the read and write strobes until the operation completes.

The stack grows downward and is predecremented. A saved pair puts its upper byte at the higher address, so the accumulator of a status word lands above the flags. A call reads its two target bytes from the instruction stream, low byte first, into the temporary registers Z and W. It then stacks the return address (call address plus 3), upper byte first, and jumps to {W,Z}. A return unstacks the low byte into Z and then the high byte into W, and loads the program counter from them. The opcode fetch is modelled as a fixed-length cycle that produces no memory strobe.

States: `ST_IDLE`, `ST_FETCH`, `ST_RD_LO`, `ST_RD_HI`, `ST_WR_HI`, `ST_WR_LO`. The transitions are:
- `ST_IDLE` goes to `ST_FETCH` on start.
- `ST_FETCH` goes to `ST_WR_HI` for a push, and to `ST_RD_LO` for every other operation.
- `ST_RD_LO` goes to `ST_RD_HI`.
- `ST_RD_HI` goes to `ST_WR_HI` for a call, and back to `ST_IDLE` otherwise.
- `ST_WR_HI` goes to `ST_WR_LO`.
- `ST_WR_LO` goes to `ST_IDLE`.

Every transition except the one out of idle happens at the last T-state of the current machine cycle.

Top module: `stack_call_seq`

## Requirements
- R1: After reset the program counter equals RESET_PC, the stack pointer equals RESET_SP, the popped pair is 0, busy is low, the T-state count is 0 and both strobes are low.
- R2: The operation code is 2'b00 push pair, 2'b01 pop pair, 2'b10 call, 2'b11 return. A start strobe is taken only while busy is low; a start during an operation is ignored and changes no bus activity or final register value.
- R3: A push takes a 6-T-state fetch and then two 3-T-state write cycles, 12 T-states in all. It writes pair_i[15:8] to SP-1 and then pair_i[7:0] to SP-2, leaves SP two lower and advances PC by 1. For a status word the accumulator (upper byte) therefore sits at the higher address.
- R4: A pop takes a 4-T-state fetch and then two 3-T-state read cycles, 10 T-states in all. It reads the low byte at SP and the high byte at SP+1, puts {high,low} on pair_o, leaves SP two higher and advances PC by 1.
- R5: A call at address P takes 18 T-states: a 6-T-state fetch, reads at P+1 (into Z) and P+2 (into W), then writes (P+3)[15:8] to SP-1 and (P+3)[7:0] to SP-2. It ends with PC = {W,Z} and SP two lower.
- R6: A return takes 10 T-states: a 4-T-state fetch, then reads at SP (into Z) and at SP+1 (into W). It ends with PC = {W,Z} and SP two higher.
- R7: Each memory read or write cycle lasts 3 T-states. Its strobe is high only in its last T-state, read and write strobes are never high together, and the fetch cycle raises no strobe.
- R8: busy is high for exactly the operation's T-state count. During the operation tstate_o counts 1, 2, … up to that count, and it is 0 when idle.
- R9: Stack pointer arithmetic wraps modulo 2^16 (a push at SP=0 writes 0xFFFF and 0xFFFE; a pop from 0xFFFE returns SP to 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start an operation (taken when idle) |
| op_i | input | 2 | Operation code |
| pair_i | input | 16 | Register pair value to push |
| mem_rdata_i | input | 8 | Memory read data, sampled in the last T-state of a read cycle |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| pair_o | output | 16 | Last popped register pair |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| busy_o | output | 1 | Operation in progress |
| tstate_o | output | 5 | T-state index within the operation |

## Verification
The bench keeps the default fetch and memory-cycle lengths and the default RESET_PC of 0x2040, but builds the block with RESET_SP set to 0x0000. The first push therefore crosses the bottom of the address space, and the SP wrap in both directions is exercised without any extra stimulus. Sequences of pushes and pops check last-in-first-out order, and a call made inside a called routine checks that nested return addresses stack correctly. A start pulse injected in the middle of a call checks that a busy sequencer ignores it.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

    typedef enum logic [1:0] {
        OP_PUSH = 2'b00,
        OP_POP  = 2'b01,
        OP_CALL = 2'b10,
        OP_RET  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_RD_LO = 3'd2,
        ST_RD_HI = 3'd3,
        ST_WR_HI = 3'd4,
        ST_WR_LO = 3'd5
    } state_e;

endpackage

// File: rtl/sq_tstate_ctr.sv
module sq_tstate_ctr #(
    parameter int T_W = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           begin_op,
    input  logic           finish,
    input  logic           run,
    input  logic [T_W-1:0] mc_len,
    output logic           mc_last,
    output logic [T_W-1:0] t_total
);

    logic [T_W-1:0] t_in_mc;

    assign mc_last = run && (t_in_mc == mc_len);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_in_mc <= T_W'(1);
            t_total <= '0;
        end else if (begin_op) begin
            t_in_mc <= T_W'(1);
            t_total <= T_W'(1);
        end else if (finish) begin
            t_in_mc <= T_W'(1);
            t_total <= '0;
        end else if (run) begin
            t_in_mc <= mc_last ? T_W'(1) : t_in_mc + T_W'(1);
            t_total <= t_total + T_W'(1);
        end
    end

    // R8
    idle_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |-> (t_total == '0));

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !finish) |=> (t_total == $past(t_total) + T_W'(1)));

endmodule

// File: rtl/sq_regs.sv
module sq_regs #(
    parameter int          AW       = 16,
    parameter int          DW       = 8,
    parameter logic [15:0] RESET_PC = 16'h2040,
    parameter logic [15:0] RESET_SP = 16'h2400
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pc_inc,
    input  logic            pc_jump,
    input  logic            sp_inc,
    input  logic            sp_dec,
    input  logic            z_load,
    input  logic            w_load,
    input  logic            pair_load,
    input  logic [DW-1:0]   rdata,
    output logic [AW-1:0]   pc,
    output logic [AW-1:0]   sp,
    output logic [2*DW-1:0] pair
);

    logic [DW-1:0] z_q;
    logic [DW-1:0] w_q;
    logic [DW-1:0] w_next;

    assign w_next = w_load ? rdata : w_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_q <= '0;
            w_q <= '0;
        end else begin
            if (z_load) z_q <= rdata;
            if (w_load) w_q <= rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= AW'(RESET_PC);
        end else if (pc_jump) begin
            pc <= AW'({w_next, z_q});
        end else if (pc_inc) begin
            pc <= pc + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= AW'(RESET_SP);
        end else if (sp_dec) begin
            sp <= sp - AW'(1);
        end else if (sp_inc) begin
            sp <= sp + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair <= '0;
        end else if (pair_load) begin
            pair <= {w_next, z_q};
        end
    end

    // R3
    sp_predec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_dec |=> (sp == $past(sp) - AW'(1)));

    // R4
    sp_postinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_inc && !sp_dec) |=> (sp == $past(sp) + AW'(1)));

    // R6
    jump_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_jump && z_load) |-> 1'b0);

endmodule

// File: rtl/sq_bus.sv
module sq_bus #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  stack_seq_pkg::state_e  state,
    input  stack_seq_pkg::op_e     op,
    input  logic                   mc_last,
    input  logic [AW-1:0]          pc,
    input  logic [AW-1:0]          sp,
    input  logic [2*DW-1:0]        push_val,
    output logic [AW-1:0]          addr,
    output logic [DW-1:0]          wdata,
    output logic                   rd,
    output logic                   wr
);
    import stack_seq_pkg::*;

    logic [2*DW-1:0] store_val;

    assign store_val = (op == OP_CALL) ? (2*DW)'(pc) : push_val;

    always_comb begin
        addr  = pc;
        wdata = '0;
        rd    = 1'b0;
        wr    = 1'b0;
        unique case (state)
            ST_IDLE, ST_FETCH: begin
                addr = pc;
            end
            ST_RD_LO, ST_RD_HI: begin
                addr = (op == OP_CALL) ? pc : sp;
                rd   = mc_last;
            end
            ST_WR_HI: begin
                addr  = sp - AW'(1);
                wdata = store_val[2*DW-1:DW];
                wr    = mc_last;
            end
            ST_WR_LO: begin
                addr  = sp - AW'(1);
                wdata = store_val[DW-1:0];
                wr    = mc_last;
            end
            default: begin
                addr = pc;
            end
        endcase
    end

    // R7
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd, wr}));

    // R7
    strobe_single_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd || wr) |=> !(rd || wr));

endmodule

// File: rtl/stack_call_seq.sv
module stack_call_seq #(
    parameter int          AW          = 16,
    parameter int          DW          = 8,
    parameter int          FETCH_LONG  = 6,
    parameter int          FETCH_SHORT = 4,
    parameter int          MEM_T       = 3,
    parameter logic [15:0] RESET_PC    = 16'h2040,
    parameter logic [15:0] RESET_SP    = 16'h2400,
    localparam int         MAX_T       = FETCH_LONG + 4 * MEM_T,
    localparam int         T_W         = $clog2(MAX_T + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      op_i,
    input  logic [2*DW-1:0] pair_i,
    input  logic [DW-1:0]   mem_rdata_i,
    output logic [AW-1:0]   mem_addr_o,
    output logic [DW-1:0]   mem_wdata_o,
    output logic            mem_rd_o,
    output logic            mem_wr_o,
    output logic [2*DW-1:0] pair_o,
    output logic [AW-1:0]   pc_o,
    output logic [AW-1:0]   sp_o,
    output logic            busy_o,
    output logic [T_W-1:0]  tstate_o
);
    import stack_seq_pkg::*;

    state_e         state_q;
    state_e         state_d;
    op_e            op_q;
    logic [2*DW-1:0] pair_q;
    logic           accept;
    logic           run;
    logic           mc_last;
    logic           finish;
    logic [T_W-1:0] mc_len;

    logic pc_inc, pc_jump, sp_inc, sp_dec, z_load, w_load, pair_load;

    function automatic logic [T_W-1:0] op_len(op_e o);
        unique case (o)
            OP_PUSH: op_len = T_W'(FETCH_LONG + 2 * MEM_T);
            OP_POP:  op_len = T_W'(FETCH_SHORT + 2 * MEM_T);
            OP_CALL: op_len = T_W'(FETCH_LONG + 4 * MEM_T);
            default: op_len = T_W'(FETCH_SHORT + 2 * MEM_T);
        endcase
    endfunction

    assign run    = (state_q != ST_IDLE);
    assign accept = !run && start_i;
    assign busy_o = run;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_PUSH;
            pair_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q   <= op_e'(op_i);
                pair_q <= pair_i;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (mc_last) state_d = (op_q == OP_PUSH) ? ST_WR_HI : ST_RD_LO;
            end
            ST_RD_LO: begin
                if (mc_last) state_d = ST_RD_HI;
            end
            ST_RD_HI: begin
                if (mc_last) state_d = (op_q == OP_CALL) ? ST_WR_HI : ST_IDLE;
            end
            ST_WR_HI: begin
                if (mc_last) state_d = ST_WR_LO;
            end
            ST_WR_LO: begin
                if (mc_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and register controls
    always_comb begin
        pc_inc    = 1'b0;
        pc_jump   = 1'b0;
        sp_inc    = 1'b0;
        sp_dec    = 1'b0;
        z_load    = 1'b0;
        w_load    = 1'b0;
        pair_load = 1'b0;
        finish    = 1'b0;
        mc_len    = T_W'(MEM_T);
        unique case (state_q)
            ST_IDLE: begin
                mc_len = T_W'(MEM_T);
            end
            ST_FETCH: begin
                mc_len = (op_q == OP_PUSH || op_q == OP_CALL) ?
                         T_W'(FETCH_LONG) : T_W'(FETCH_SHORT);
                pc_inc = mc_last;
            end
            ST_RD_LO: begin
                z_load = mc_last;
                pc_inc = mc_last && (op_q == OP_CALL);
                sp_inc = mc_last && (op_q != OP_CALL);
            end
            ST_RD_HI: begin
                w_load    = mc_last;
                pc_inc    = mc_last && (op_q == OP_CALL);
                sp_inc    = mc_last && (op_q != OP_CALL);
                pc_jump   = mc_last && (op_q == OP_RET);
                pair_load = mc_last && (op_q == OP_POP);
                finish    = mc_last && (op_q != OP_CALL);
            end
            ST_WR_HI: begin
                sp_dec = mc_last;
            end
            ST_WR_LO: begin
                sp_dec  = mc_last;
                pc_jump = mc_last && (op_q == OP_CALL);
                finish  = mc_last;
            end
            default: begin
                mc_len = T_W'(MEM_T);
            end
        endcase
    end

    sq_tstate_ctr #(
        .T_W (T_W)
    ) u_tctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .begin_op (accept),
        .finish   (finish),
        .run      (run),
        .mc_len   (mc_len),
        .mc_last  (mc_last),
        .t_total  (tstate_o)
    );

    sq_regs #(
        .AW       (AW),
        .DW       (DW),
        .RESET_PC (RESET_PC),
        .RESET_SP (RESET_SP)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .pc_inc    (pc_inc),
        .pc_jump   (pc_jump),
        .sp_inc    (sp_inc),
        .sp_dec    (sp_dec),
        .z_load    (z_load),
        .w_load    (w_load),
        .pair_load (pair_load),
        .rdata     (mem_rdata_i),
        .pc        (pc_o),
        .sp        (sp_o),
        .pair      (pair_o)
    );

    sq_bus #(
        .AW (AW),
        .DW (DW)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state_q),
        .op       (op_q),
        .mc_last  (mc_last),
        .pc       (pc_o),
        .sp       (sp_o),
        .push_val (pair_q),
        .addr     (mem_addr_o),
        .wdata    (mem_wdata_o),
        .rd       (mem_rd_o),
        .wr       (mem_wr_o)
    );

    // R2
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (op_q == $past(op_q)));

    // R8
    op_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(tstate_o) == op_len(op_q)));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o) |-> !(mem_rd_o || mem_wr_o));

    // R5
    call_sp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_LO && mc_last) |=> (sp_o == $past(sp_o) - AW'(1)));

endmodule

// File: tb/stack_call_seq_tb.sv
module stack_call_seq_tb_top;
    import stack_seq_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [15:0] pair_i = '0;
    logic [7:0]  mem_rdata_i;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic        mem_rd_o;
    logic        mem_wr_o;
    logic [15:0] pair_o;
    logic [15:0] pc_o;
    logic [15:0] sp_o;
    logic        busy_o;
    logic [4:0]  tstate_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        bit          wr;
        logic [15:0] addr;
        logic [7:0]  data;
    } bus_ev_t;

    bus_ev_t exp_q[$];

    logic [7:0] mem [0:4095];

    always #(CLK_PERIOD/2) clk = ~clk;

    stack_call_seq #(
        .RESET_SP (16'h0000)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .op_i        (op_i),
        .pair_i      (pair_i),
        .mem_rdata_i (mem_rdata_i),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rd_o    (mem_rd_o),
        .mem_wr_o    (mem_wr_o),
        .pair_o      (pair_o),
        .pc_o        (pc_o),
        .sp_o        (sp_o),
        .busy_o      (busy_o),
        .tstate_o    (tstate_o)
    );

    assign mem_rdata_i = mem[mem_addr_o[11:0]];

    always @(posedge clk) begin
        if (mem_wr_o) mem[mem_addr_o[11:0]] <= mem_wdata_o;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic exp_rd(input logic [15:0] a);
        bus_ev_t e;
        e.wr = 1'b0; e.addr = a; e.data = '0;
        exp_q.push_back(e);
    endtask

    task automatic exp_wr(input logic [15:0] a, input logic [7:0] d);
        bus_ev_t e;
        e.wr = 1'b1; e.addr = a; e.data = d;
        exp_q.push_back(e);
    endtask

    // monitor: compare every strobe against the scoreboard queue (R7, R3..R6)
    always @(negedge clk) begin
        if (rst_n && !finished && (mem_rd_o || mem_wr_o)) begin
            if (mem_rd_o && mem_wr_o) begin
                chk(1'b0, "R7", "both strobes", 32'd1, 32'd0);
            end else if (exp_q.size() == 0) begin
                chk(1'b0, "R7", "unexpected strobe addr", 32'(mem_addr_o), 32'hFFFF_FFFF);
            end else begin
                bus_ev_t e;
                e = exp_q.pop_front();
                chk(e.wr == mem_wr_o, "R7", "strobe kind", 32'(mem_wr_o), 32'(e.wr));
                chk(e.addr == mem_addr_o, "R7", "strobe addr", 32'(mem_addr_o), 32'(e.addr));
                if (e.wr)
                    chk(e.data == mem_wdata_o, "R3", "write data", 32'(mem_wdata_o), 32'(e.data));
            end
        end
    end

    task automatic run_op(input op_e op, input logic [15:0] pv, input int n,
                          input int inject, input string req);
        int bad_t = 0;
        @(negedge clk);
        start_i = 1'b1;
        op_i    = op;
        pair_i  = pv;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 1; i <= n; i++) begin
            if (i == inject) begin
                start_i = 1'b1;
                op_i    = OP_POP;
                pair_i  = 16'hDEAD;
            end else begin
                start_i = 1'b0;
            end
            if (!(busy_o && tstate_o == 5'(i))) bad_t++;
            @(negedge clk);
        end
        start_i = 1'b0;
        // R8 busy length and T-state count
        chk(bad_t == 0 && !busy_o && tstate_o == 0, req, "R8 T-state schedule",
            32'(bad_t), 32'd0);
        chk(exp_q.size() == 0, req, "R7 pending bus events", 32'(exp_q.size()), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        mem[12'h047] = 8'h70;
        mem[12'h048] = 8'h21;
        mem[12'h04A] = 8'h00;
        mem[12'h04B] = 8'h30;
        mem[12'h001] = 8'h34;
        mem[12'h002] = 8'h12;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pc_o == 16'h2040, "R1", "pc", 32'(pc_o), 32'h2040);
        chk(sp_o == 16'h0000, "R1", "sp", 32'(sp_o), 32'h0);
        chk(!busy_o && tstate_o == 0, "R1", "busy/tstate", {busy_o, tstate_o}, 0);
        chk(!mem_rd_o && !mem_wr_o && pair_o == 0, "R1", "strobes/pair",
            {mem_rd_o, mem_wr_o, pair_o}, 0);

        // R3 R9 push status word at SP=0 wraps
        exp_wr(16'hFFFF, 8'hA5);
        exp_wr(16'hFFFE, 8'h5A);
        run_op(OP_PUSH, 16'hA55A, 12, 0, "R3");
        chk(sp_o == 16'hFFFE, "R9", "sp after push", 32'(sp_o), 32'hFFFE);
        chk(pc_o == 16'h2041, "R3", "pc after push", 32'(pc_o), 32'h2041);

        // R4 R9 pop back
        exp_rd(16'hFFFE);
        exp_rd(16'hFFFF);
        run_op(OP_POP, 16'h0000, 10, 0, "R4");
        chk(pair_o == 16'hA55A, "R4", "popped pair", 32'(pair_o), 32'hA55A);
        chk(sp_o == 16'h0000, "R9", "sp after pop", 32'(sp_o), 32'h0);
        chk(pc_o == 16'h2042, "R4", "pc after pop", 32'(pc_o), 32'h2042);

        // R3 R4 last-in-first-out with two pairs
        exp_wr(16'hFFFF, 8'h12);
        exp_wr(16'hFFFE, 8'h34);
        run_op(OP_PUSH, 16'h1234, 12, 0, "R3");
        exp_wr(16'hFFFD, 8'hBE);
        exp_wr(16'hFFFC, 8'hEF);
        run_op(OP_PUSH, 16'hBEEF, 12, 0, "R3");
        chk(sp_o == 16'hFFFC, "R3", "sp after two pushes", 32'(sp_o), 32'hFFFC);
        exp_rd(16'hFFFC);
        exp_rd(16'hFFFD);
        run_op(OP_POP, 16'h0000, 10, 0, "R4");
        chk(pair_o == 16'hBEEF, "R4", "first pop", 32'(pair_o), 32'hBEEF);
        exp_rd(16'hFFFE);
        exp_rd(16'hFFFF);
        run_op(OP_POP, 16'h0000, 10, 0, "R4");
        chk(pair_o == 16'h1234, "R4", "second pop", 32'(pair_o), 32'h1234);
        chk(pc_o == 16'h2046, "R4", "pc after pops", 32'(pc_o), 32'h2046);

        // R5 call at 0x2046 to 0x2170, return address 0x2049
        exp_rd(16'h2047);
        exp_rd(16'h2048);
        exp_wr(16'hFFFF, 8'h20);
        exp_wr(16'hFFFE, 8'h49);
        run_op(OP_CALL, 16'h0000, 18, 0, "R5");
        chk(pc_o == 16'h2170, "R5", "pc after call", 32'(pc_o), 32'h2170);
        chk(sp_o == 16'hFFFE, "R5", "sp after call", 32'(sp_o), 32'hFFFE);

        // R6 return
        exp_rd(16'hFFFE);
        exp_rd(16'hFFFF);
        run_op(OP_RET, 16'h0000, 10, 0, "R6");
        chk(pc_o == 16'h2049, "R6", "pc after return", 32'(pc_o), 32'h2049);
        chk(sp_o == 16'h0000, "R6", "sp after return", 32'(sp_o), 32'h0);

        // R2 call with a start injected mid-operation (ignored)
        exp_rd(16'h204A);
        exp_rd(16'h204B);
        exp_wr(16'hFFFF, 8'h20);
        exp_wr(16'hFFFE, 8'h4C);
        run_op(OP_CALL, 16'h0000, 18, 7, "R2");
        chk(pc_o == 16'h3000 && sp_o == 16'hFFFE, "R2", "pc/sp after ignored start",
            {pc_o, sp_o}, {16'h3000, 16'hFFFE});
        chk(pair_o == 16'h1234, "R2", "pair untouched", 32'(pair_o), 32'h1234);

        // R5 nested call at 0x3000 to 0x1234
        exp_rd(16'h3001);
        exp_rd(16'h3002);
        exp_wr(16'hFFFD, 8'h30);
        exp_wr(16'hFFFC, 8'h03);
        run_op(OP_CALL, 16'h0000, 18, 0, "R5");
        chk(pc_o == 16'h1234 && sp_o == 16'hFFFC, "R5", "nested call pc/sp",
            {pc_o, sp_o}, {16'h1234, 16'hFFFC});

        // R6 unwind both levels
        exp_rd(16'hFFFC);
        exp_rd(16'hFFFD);
        run_op(OP_RET, 16'h0000, 10, 0, "R6");
        chk(pc_o == 16'h3003, "R6", "inner return pc", 32'(pc_o), 32'h3003);
        exp_rd(16'hFFFE);
        exp_rd(16'hFFFF);
        run_op(OP_RET, 16'h0000, 10, 0, "R6");
        chk(pc_o == 16'h204C && sp_o == 16'h0000, "R6", "outer return pc/sp",
            {pc_o, sp_o}, {16'h204C, 16'h0000});

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL R8 watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule